// File: doc/BRIEF.md
# Event Counter Bank with Overflow Tracking

This block holds a set of 64-bit event counters. Each counter has a companion selector register that keeps an event identifier and a sticky overflow flag. An external filter decides which events match and drives one increment strobe per counter. The bank adds one to every counter whose strobe is high and whose inhibit bit is clear. When a counter wraps past all ones, the bank records the overflow in a shared status word and raises a one-cycle interrupt pulse.

Software reaches the counters and selectors through a single write port and a combinational read port. The write port selects a counter or a selector by index. A write to a selector checks the event identifier and replaces any value outside the legal range with zero, which means "count nothing". A selector write with the overflow flag low clears that counter's bit in the status word. In both the status word and the inhibit word, bit 0 belongs to a cycle counter kept elsewhere, so counter k uses bit k+1.

Top module: `evt_ctr_bank`

## Requirements
- R1: After reset, all counters and selectors read zero, the status word is zero and irq_o is low.
- R2: When inc_i[k] is high and inhibit_i[k+1] is low, counter k increases by one at the clock edge.
- R3: While inhibit_i[k+1] is high, inc_i[k] leaves counter k unchanged.
- R4: When counter k increments from all ones, it becomes zero. If status bit k+1 was clear, the same edge sets status bit k+1 and selector k bit 63, and irq_o is high for exactly one cycle.
- R5: A wrap of counter k while status bit k+1 is already set raises no interrupt and leaves the status word unchanged.
- R6: A selector write to index k with data bit 63 low clears status bit k+1.
- R7: On a selector write, the event ID field (selector bits 14:0) is stored only when 0 < ID < EVT_ID_MAX; any other value is stored as 0. Other data bits except bit 63 read back as zero.
- R8: Writes to an index at or above NUM_CTR change nothing, and reads at such an index return zero.
- R9: When several counters wrap in the same cycle with their status bits clear, all of their status bits are set together and a single one-cycle irq_o pulse is produced.
- R10: Status bit 0 and all status bits above NUM_CTR always read zero, and a status bit is cleared only by a selector write.
- R11: A counter write to index k in the same cycle as an increment of k stores the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inc_i | input | NUM_CTR | Per-counter increment strobe |
| inhibit_i | input | 32 | Inhibit word; bit k+1 freezes counter k |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 counter, 1 selector |
| wr_idx_i | input | 5 | Write index |
| wr_data_i | input | 64 | Write data |
| rd_sel_i | input | 1 | Read target: 0 counter, 1 selector |
| rd_idx_i | input | 5 | Read index |
| rd_data_o | output | 64 | Read data (combinational) |
| ovf_status_o | output | 32 | Overflow status word; bit k+1 belongs to counter k |
| irq_o | output | 1 | Interrupt pulse on a new overflow |

## Verification
The bench builds the bank with NUM_CTR=4 and EVT_ID_MAX=20. With these values, indices 4 to 31 on the 5-bit index fall outside the implemented range, so writes there can be tested as ignored. Both ends of the legal ID range (19 kept, 20 and 0x7fff zeroed) are checked directly. The counters are kept at 64 bits. Writing all ones into a counter brings a wrap within one increment, for single wraps, repeated wraps and simultaneous wraps.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;
  localparam int unsigned CTR_W   = 64;
  localparam int unsigned ID_W    = 15;
  localparam int unsigned IDX_W   = 5;
  localparam int unsigned STAT_W  = 32;
  localparam int unsigned OVF_BIT = 63;

  typedef logic [CTR_W-1:0] word_t;
  typedef logic [ID_W-1:0]  evt_id_t;

  // out-of-range IDs collapse to 0 (counts nothing)
  function automatic evt_id_t legal_id(input evt_id_t id, input int unsigned id_max);
    if (id != '0 && 32'(id) < id_max) return id;
    return '0;
  endfunction
endpackage

// File: rtl/evt_ctr_slot.sv
module evt_ctr_slot
  import evt_ctr_pkg::*;
#(
  parameter int unsigned EVT_ID_MAX = 100
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cnt_we_i,
  input  logic  sel_we_i,
  input  word_t wdata_i,
  input  logic  inc_i,
  input  logic  inh_i,
  input  logic  stat_i,
  output word_t cnt_o,
  output word_t sel_o,
  output logic  set_o,
  output logic  clr_o
);
  word_t   cnt_q;
  evt_id_t id_q;
  logic    flag_q;
  logic    inc_en;
  logic    wrap;

  assign inc_en = inc_i && !inh_i && !cnt_we_i;
  assign wrap   = inc_en && (&cnt_q);
  assign set_o  = wrap && !stat_i;
  assign clr_o  = sel_we_i && !wdata_i[OVF_BIT] && stat_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_we_i) begin
      cnt_q <= wdata_i;
    end else if (inc_en) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      if (sel_we_i) id_q <= legal_id(wdata_i[ID_W-1:0], EVT_ID_MAX);
      if (set_o)         flag_q <= 1'b1;
      else if (sel_we_i) flag_q <= wdata_i[OVF_BIT];
    end
  end

  assign cnt_o = cnt_q;
  always_comb begin
    sel_o            = '0;
    sel_o[ID_W-1:0]  = id_q;
    sel_o[OVF_BIT]   = flag_q;
  end
endmodule

// File: rtl/evt_ovf_status.sv
module evt_ovf_status
  import evt_ctr_pkg::*;
#(
  parameter int unsigned NUM_CTR = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CTR-1:0] set_i,
  input  logic [NUM_CTR-1:0] clr_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o
);
  logic [NUM_CTR-1:0] bits_q;
  logic               irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      bits_q <= set_i | (bits_q & ~clr_i);
      irq_q  <= |set_i;
    end
  end

  // bit 0 reserved for the external cycle counter
  always_comb begin
    stat_o                = '0;
    stat_o[NUM_CTR:1]     = bits_q;
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank
  import evt_ctr_pkg::*;
#(
  parameter int unsigned NUM_CTR    = 8,
  parameter int unsigned EVT_ID_MAX = 100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CTR-1:0] inc_i,
  input  logic [STAT_W-1:0]  inhibit_i,
  input  logic               wr_en_i,
  input  logic               wr_sel_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [CTR_W-1:0]   wr_data_i,
  input  logic               rd_sel_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [CTR_W-1:0]   rd_data_o,
  output logic [STAT_W-1:0]  ovf_status_o,
  output logic               irq_o
);
  word_t              cnt   [NUM_CTR];
  word_t              sel   [NUM_CTR];
  logic [NUM_CTR-1:0] set_v;
  logic [NUM_CTR-1:0] clr_v;
  logic [STAT_W-1:0]  stat;

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_slot
    logic hit;
    assign hit = wr_en_i && (32'(wr_idx_i) == k);

    evt_ctr_slot #(.EVT_ID_MAX(EVT_ID_MAX)) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cnt_we_i (hit && !wr_sel_i),
      .sel_we_i (hit && wr_sel_i),
      .wdata_i  (wr_data_i),
      .inc_i    (inc_i[k]),
      .inh_i    (inhibit_i[k+1]),
      .stat_i   (stat[k+1]),
      .cnt_o    (cnt[k]),
      .sel_o    (sel[k]),
      .set_o    (set_v[k]),
      .clr_o    (clr_v[k])
    );
  end

  evt_ovf_status #(.NUM_CTR(NUM_CTR)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .stat_o (stat),
    .irq_o  (irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NUM_CTR; k++) begin
      if (32'(rd_idx_i) == k) rd_data_o = rd_sel_i ? sel[k] : cnt[k];
    end
  end

  assign ovf_status_o = stat;
endmodule

// File: rtl/evt_ctr_bank_chk.sv
module evt_ctr_bank_chk
  import evt_ctr_pkg::*;
#(
  parameter int unsigned NUM_CTR = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              wr_sel_i,
  input logic [STAT_W-1:0] ovf_status_o,
  input logic              irq_o
);
  localparam logic [STAT_W-1:0] LIVE = ((STAT_W)'(1) << (NUM_CTR + 1)) - (STAT_W)'(2);

  p_reserved_bits_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_status_o & ~LIVE) == '0);

  p_irq_has_new_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((ovf_status_o & ~$past(ovf_status_o)) != '0));

  p_new_bit_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ovf_status_o & ~$past(ovf_status_o)) != '0) |-> irq_o);

  p_clear_by_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(ovf_status_o) & ~ovf_status_o) != '0) |-> $past(wr_en_i && wr_sel_i));

  p_no_set_no_irq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(irq_o) && irq_o) |-> ((ovf_status_o & ~$past(ovf_status_o)) != '0));
endmodule

bind evt_ctr_bank evt_ctr_bank_chk #(.NUM_CTR(NUM_CTR)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_sel_i     (wr_sel_i),
  .ovf_status_o (ovf_status_o),
  .irq_o        (irq_o)
);

// File: tb/tb_evt_ctr_bank.sv
module tb_evt_ctr_bank;
  localparam int unsigned N    = 4;
  localparam int unsigned IMAX = 20;
  localparam logic [63:0] ONES = '1;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [N-1:0] inc_i = '0;
  logic [31:0] inhibit_i = '0;
  logic        wr_en_i = 1'b0, wr_sel_i = 1'b0, rd_sel_i = 1'b0;
  logic [4:0]  wr_idx_i = '0, rd_idx_i = '0;
  logic [63:0] wr_data_i = '0, rd_data_o;
  logic [31:0] ovf_status_o;
  logic        irq_o;
  int          errors = 0, checks = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  evt_ctr_bank #(.NUM_CTR(N), .EVT_ID_MAX(IMAX)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .inc_i(inc_i), .inhibit_i(inhibit_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
    .rd_sel_i(rd_sel_i), .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o),
    .ovf_status_o(ovf_status_o), .irq_o(irq_o)
  );

  // {idx, id written, id expected}
  localparam logic [39:0] VEC [6] = '{
    {8'd0, 16'd5,      16'd5},
    {8'd1, 16'd0,      16'd0},
    {8'd2, 16'd19,     16'd19},
    {8'd3, 16'd20,     16'd0},
    {8'd0, 16'h7fff,   16'd0},
    {8'd1, 16'h0001,   16'd1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input int idx, input logic [63:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = s; wr_idx_i = 5'(idx); wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic s, input int idx, output logic [63:0] d);
    rd_sel_i = s; rd_idx_i = 5'(idx);
    #1 d = rd_data_o;
  endtask

  // strobe for one edge; returns at the following negedge
  task automatic pulse(input logic [N-1:0] m);
    @(negedge clk);
    inc_i = m;
    @(negedge clk);
    inc_i = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int k = 0; k < N; k++) begin
      rd(1'b0, k, d); chk("R1 counter", d, 64'd0);
      rd(1'b1, k, d); chk("R1 selector", d, 64'd0);
    end
    chk("R1 status", 64'(ovf_status_o), 64'd0);
    chk("R1 irq", 64'(irq_o), 64'd0);

    // R7 event ID legalisation via table
    for (int i = 0; i < 6; i++) begin
      wr(1'b1, int'(VEC[i][39:32]), {48'h0000_0000_0010, VEC[i][31:16]} | 64'h0010_0000);
      rd(1'b1, int'(VEC[i][39:32]), d);
      chk("R7 event id", d, {48'd0, VEC[i][15:0]});
    end

    // R2 increments
    wr(1'b0, 1, 64'd0);
    pulse(4'b0010); pulse(4'b0010); pulse(4'b0010);
    rd(1'b0, 1, d); chk("R2 count", d, 64'd3);

    // R3 inhibit
    inhibit_i = 32'h4;
    pulse(4'b0010);
    rd(1'b0, 1, d); chk("R3 inhibited", d, 64'd3);
    inhibit_i = 32'h1;  // cycle-counter bit must not affect counter 0/1
    pulse(4'b0010);
    rd(1'b0, 1, d); chk("R2 bit0 inhibit ignored", d, 64'd4);
    inhibit_i = '0;

    // R11 write beats increment
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = 1'b0; wr_idx_i = 5'd1; wr_data_i = 64'd100; inc_i = 4'b0010;
    @(negedge clk);
    wr_en_i = 1'b0; inc_i = '0;
    rd(1'b0, 1, d); chk("R11 write priority", d, 64'd100);

    // R4 wrap with interrupt
    wr(1'b1, 0, 64'd5);
    wr(1'b0, 0, ONES);
    pulse(4'b0001);
    chk("R4 irq high", 64'(irq_o), 64'd1);
    chk("R4 status", 64'(ovf_status_o), 64'h2);
    rd(1'b0, 0, d); chk("R4 wrap zero", d, 64'd0);
    rd(1'b1, 0, d); chk("R4 selector flag", d, 64'h8000_0000_0000_0005);
    @(negedge clk);
    chk("R4 irq one cycle", 64'(irq_o), 64'd0);

    // R5 second wrap with bit already set
    wr(1'b0, 0, ONES);
    pulse(4'b0001);
    chk("R5 no irq", 64'(irq_o), 64'd0);
    chk("R5 status kept", 64'(ovf_status_o), 64'h2);
    rd(1'b0, 0, d); chk("R5 wrap zero", d, 64'd0);

    // R6 clear via selector write
    wr(1'b1, 0, 64'd5);
    chk("R6 status cleared", 64'(ovf_status_o), 64'h0);
    rd(1'b1, 0, d); chk("R6 selector", d, 64'd5);

    // R9 simultaneous wraps
    wr(1'b0, 2, ONES);
    wr(1'b0, 3, ONES);
    pulse(4'b1100);
    chk("R9 status both", 64'(ovf_status_o), 64'h18);
    chk("R9 irq", 64'(irq_o), 64'd1);
    @(negedge clk);
    chk("R9 single pulse", 64'(irq_o), 64'd0);

    // R8 out-of-range index
    wr(1'b0, 5, 64'd77);
    wr(1'b1, 31, 64'd3);
    rd(1'b0, 5, d); chk("R8 read zero", d, 64'd0);
    rd(1'b0, 1, d); chk("R8 ctr1 kept", d, 64'd100);
    rd(1'b1, 3, d); chk("R8 sel3 kept", d, 64'h8000_0000_0000_0000);
    chk("R8 status kept", 64'(ovf_status_o), 64'h18);

    // R10 reserved status bits
    chk("R10 bit0 zero", 64'(ovf_status_o[0]), 64'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule